// File: doc/BRIEF.md
# Multi-Mode Variable Shifter

This block moves a W-bit data word by a variable, unsigned distance in one of six ways: logical left, logical right, arithmetic left, arithmetic right, rotate left and rotate right. The arithmetic modes treat the word as a signed value. A right arithmetic shift copies the sign bit into the vacated upper bits. A left arithmetic shift copies the original least significant bit into the vacated lower bits, so it does not zero-fill.

The shift itself is one combinational stage. When the `REG_OUT` parameter is 1, which is the default, a register captures the result on each clock edge where `en` is high. The register clears to zero on reset. When `REG_OUT` is 0, the result goes straight to the output.

Top module: `shift_unit`

## Requirements
- R1: Mode code 3'b000 (logical left) moves every bit up by `amt` places and fills the vacated low bits with 0. For example, 0x004A shifted by 2 gives 0x0128.
- R2: Mode code 3'b001 (logical right) moves every bit down by `amt` places and fills the vacated high bits with 0.
- R3: Mode code 3'b010 (arithmetic left) moves every bit up by `amt` places and fills the vacated low bits with copies of the original bit 0.
- R4: Mode code 3'b011 (arithmetic right) moves every bit down by `amt` places and fills the vacated high bits with copies of the original bit W-1.
- R5: Mode code 3'b100 rotates left and mode code 3'b101 rotates right. Bits leaving one end re-enter at the other end, and the effective distance is `amt` modulo W.
- R6: In the four non-rotating modes, an `amt` of W or more gives a word made entirely of fill bits: all zeros for modes 000 and 001, all copies of bit 0 for mode 010, and all copies of bit W-1 for mode 011.
- R7: An `amt` of 0 returns `data_in` unchanged in every mode.
- R8: Mode codes 3'b110 and 3'b111 pass `data_in` through unchanged, whatever the value of `amt`.
- R9: With the output register enabled, `data_out` is 0 after reset. It takes the shifted result on a rising edge where `en` is 1, and holds its value on edges where `en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Load enable for the output register |
| data_in | input | W | Word to be shifted |
| amt | input | CNT_W | Unsigned shift distance |
| mode | input | 3 | Shift mode select |
| data_out | output | W | Shifted word, registered or direct |

## Verification
The hardest cases to reach are the boundaries around the word width. These are distances of exactly W-1, W, and beyond W, where a non-rotating mode saturates to its fill value while a rotate wraps around modulo W. An arithmetic left shift also only shows its distinctive fill when bit 0 of the data is 1. The stimulus therefore sweeps every distance from 0 to W+2 in every mode, using data words that include set and clear low bits and set and clear sign bits. Each result is compared with a bit-by-bit reference model written in the bench.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W       = 16,
  parameter int CNT_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [W-1:0]     data_in,
  input  logic [CNT_W-1:0] amt,
  input  logic [2:0]       mode,
  output logic [W-1:0]     data_out
);
  localparam logic [2:0] M_SLL = 3'd0;
  localparam logic [2:0] M_SRL = 3'd1;
  localparam logic [2:0] M_SLA = 3'd2;
  localparam logic [2:0] M_SRA = 3'd3;
  localparam logic [2:0] M_ROL = 3'd4;
  localparam logic [2:0] M_ROR = 3'd5;
  localparam logic [W-1:0] ONES = '1;

  int unsigned rot;
  logic [W-1:0] res;

  assign rot = 32'(amt) % W;

  always_comb begin
    case (mode)
      M_SLL:   res = data_in << amt;
      M_SRL:   res = data_in >> amt;
      M_SLA:   res = (data_in << amt) | ({W{data_in[0]}} & ~(ONES << amt));
      M_SRA:   res = (data_in >> amt) | ({W{data_in[W-1]}} & ~(ONES >> amt));
      M_ROL:   res = (data_in << rot) | (data_in >> (W - rot));
      M_ROR:   res = (data_in >> rot) | (data_in << (W - rot));
      default: res = data_in;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  data_out <= '0;
        else if (en) data_out <= res;
      end

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(data_out)) else $error("hold violated"); // R9
      AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && amt == '0) |=> data_out == $past(data_in)) else $error("zero count"); // R7
      AST_PASS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode[2:1] == 2'b11) |=> data_out == $past(data_in)) else $error("pass"); // R8
      AST_SLL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == M_SLL && 32'(amt) >= W) |=> data_out == '0) else $error("sll sat"); // R6
      AST_SRA_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == M_SRA && 32'(amt) >= W) |=> data_out == {W{$past(data_in[W-1])}}) else $error("sra sat"); // R6
      AST_ROL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == M_ROL && 32'(amt) == W) |=> data_out == $past(data_in)) else $error("rol wrap"); // R5
    end else begin : g_comb
      assign data_out = res;
    end
  endgenerate
endmodule

// File: tb/shift_unit_tb.sv
`timescale 1ns/1ps
module shift_unit_tb;
  localparam int W = 16;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [CNT_W-1:0] amt = '0;
  logic [2:0] mode = '0;
  logic [W-1:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_unit #(.W(W), .CNT_W(CNT_W), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .data_in(data_in),
    .amt(amt), .mode(mode), .data_out(data_out));

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int k, input logic [2:0] m);
    logic [W-1:0] r;
    int rk;
    rk = k % W;
    for (int i = 0; i < W; i++) begin
      case (m)
        3'd0: r[i] = (i - k >= 0) ? d[i-k] : 1'b0;
        3'd1: r[i] = (i + k < W) ? d[i+k] : 1'b0;
        3'd2: r[i] = (i - k >= 0) ? d[i-k] : d[0];
        3'd3: r[i] = (i + k < W) ? d[i+k] : d[W-1];
        3'd4: r[i] = d[(i - rk + W) % W];
        3'd5: r[i] = d[(i + rk) % W];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string tag(input logic [2:0] m, input int k);
    if (k == 0) return "R7";
    if (m >= 3'd6) return "R8";
    if (m >= 3'd4) return "R5";
    if (k >= W) return "R6";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (data_out !== exp) begin
      errors++;
      $display("FAIL %s: mode=%0d amt=%0d data=%h actual=%h expected=%h",
               req, mode, amt, data_in, data_out, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input int k, input logic [2:0] m);
    @(negedge clk);
    data_in = d; amt = CNT_W'(k); mode = m; en = 1'b1;
    @(posedge clk); #1;
    check(tag(m, k), model(d, k, m));
  endtask

  task automatic t_reset;
    #1; check("R9", '0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; check("R9", '0);
  endtask

  task automatic t_examples;
    apply(16'h004A, 2, 3'd0);
    check("R1", 16'h0128);
    apply(16'h8001, 3, 3'd2);
    check("R3", 16'h0008 | 16'h0007);
    apply(16'h8000, 4, 3'd3);
    check("R4", 16'hF800);
    apply(16'h8001, 1, 3'd4);
    check("R5", 16'h0003);
    apply(16'h8001, 1, 3'd5);
    check("R5", 16'hC000);
  endtask

  task automatic t_sweep;
    logic [W-1:0] pats [6];
    pats[0] = 16'hA5C3; pats[1] = 16'h5A3C; pats[2] = 16'h8001;
    pats[3] = 16'h7FFE; pats[4] = W'($urandom); pats[5] = W'($urandom);
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 6; p++)
        for (int k = 0; k <= W + 2; k++)
          apply(pats[p], k, 3'(m));
  endtask

  task automatic t_hold;
    logic [W-1:0] held;
    apply(16'h1234, 4, 3'd0);
    held = data_out;
    @(negedge clk);
    en = 1'b0; data_in = 16'hFFFF; amt = 5'd1; mode = 3'd1;
    repeat (3) @(posedge clk);
    #1; check("R9", held);
    check("R9", 16'h2340);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_examples();
    t_sweep();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule